// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings an LCD panel controller from deep standby into RGB-interface display mode, and later returns it to sleep. It steps through two fixed tables of register writes. The wake table has 44 entries and the sleep table has 4. Both tables are held in constant logic inside the block. Each entry goes to a downstream serial write engine as one request. That engine accepts the address, a payload length of zero, one or two bytes, and the payload value. It answers with a one-cycle done pulse, and it may raise an error flag in the same cycle.

The wake table opens with a reset preamble of three bare null commands. After each one the block idles for a programmable number of clock cycles, `WAIT_CYC`, which stands in for the 1 ms settling time. If the engine reports an error during the preamble, the block stops at once. Errors reported later are collected, and the verdict is given only after the last entry. The panel is reported as active only when the display-on command has completed with no error recorded.

A one-cycle pulse on `en_req` starts the wake table, and a one-cycle pulse on `dis_req` starts the sleep table. Software can send either request at any time. A request that does not fit the current status does nothing.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `busy`, `active`, `err` and `wr_req` are all low.
- R2: The wake table begins with three writes to address 0x00 with `wr_len`=0. After each of them `wr_req` stays low for exactly `WAIT_CYC` cycles after the done cycle. Every other entry, in either table, presents the next request on the cycle after done.
- R3: After the preamble, the wake table issues these writes in order, given as address/length/value, where length counts payload bytes and a two-byte value sends its high byte first. B0/1/17, BC/1/80, 3B/1/00, B0/1/16, B8/2/FFF9, 11/0, BA/1/01, BB/1/00, 3A/1/60, BF/1/10, B1/1/56, B2/1/33, B3/1/11, B3/1/11, B4/1/02, B5/1/2B, B6/1/40, B7/1/03, B9/1/04, BD/1/04, BE/1/00, C0/1/11, C1/1/11, C2/1/11, C3/2/2040, C4/2/60C0, C5/2/1020, C6/2/60C0, C7/2/5533, C8/1/00, C9/1/00, CA/1/00, EC/2/01F0, CF/1/02, D0/2/0804, D1/1/01, D2/2/0000, D3/2/0D0E, D4/2/11A4, D5/1/0E, 29/0.
- R4: While `wr_req` is high and `wr_done` is low, `wr_req`, `wr_addr`, `wr_len` and `wr_data` hold their values.
- R5: If `wr_err` is high with `wr_done` on any of the three preamble writes, no further request is made, `busy` falls, `err` is set and `active` stays low.
- R6: An error reported on any later entry of either table does not stop the table. After the last entry, `err` is set and `active` ends low.
- R7: `active` rises only on completion of the display-on write 0x29, and only if no error was reported during that wake table. A clean wake table clears `err`.
- R8: The sleep table is 28/0, B8/2/8002, 10/0, B0/1/00, in that order. A clean sleep table ends with `active` and `err` both low.
- R9: `en_req` while active and `dis_req` while not active produce no write, and `busy` stays low. This holds even when the two requests arrive in the same cycle; the request that fits the current status is the one carried out.
- R10: `busy` is high from the cycle after an accepted request until the last done. Requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Pulse: run the wake table |
| dis_req | input | 1 | Pulse: run the sleep table |
| wr_req | output | 1 | Write request to the serial engine |
| wr_addr | output | 8 | Register/command address |
| wr_len | output | 2 | Payload bytes (0, 1 or 2) |
| wr_data | output | 16 | Payload; one byte in [7:0], two bytes in [15:0] with high byte first |
| wr_done | input | 1 | Engine completed the current write |
| wr_err | input | 1 | Engine reports an error, valid with wr_done |
| busy | output | 1 | A table is being run |
| active | output | 1 | Panel is awake in display mode |
| err | output | 1 | The last table reported an error |

## Verification
The bench gives an error on the second preamble write and checks that the wake table stops there. A design that treated the preamble like the rest of the table would send the remaining 42 writes. It also gives an error deep in each table and checks that every entry is still sent while `active` is withheld. A design that aborted early, or one that forgot the error, would show as a shortened table or as `active` set. It counts the idle cycles after every write, which shows whether the wait follows exactly the three preamble entries and is exactly as long as it should be. It also sends requests while the block is busy, and requests that do not fit the current status, with the downstream engine answering at a different latency each time. A design that ignored status or busy would issue extra writes.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int LEN_W     = 2;
  localparam int PRE_STEPS = 3;
  localparam int UP_STEPS  = 44;
  localparam int DN_STEPS  = 4;
  localparam int IDX_W     = $clog2(UP_STEPS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_PAUSE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
    logic              pause;
  } step_t;

  function automatic step_t mk(input logic [ADDR_W-1:0] a, input int n,
                               input logic [DATA_W-1:0] d, input logic p);
    step_t s;
    s.addr  = a;
    s.len   = LEN_W'(n);
    s.data  = d;
    s.pause = p;
    return s;
  endfunction
endpackage

// File: rtl/pps_table.sv
module pps_table
  import pps_pkg::*;
(
  input  logic             sel_down,
  input  logic [IDX_W-1:0] idx,
  output step_t            step,
  output logic             last
);
  always_comb begin
    step = '0;
    if (sel_down) begin
      case (idx)
        6'd0: step = mk(8'h28, 0, 16'h0000, 1'b0);
        6'd1: step = mk(8'hB8, 2, 16'h8002, 1'b0);
        6'd2: step = mk(8'h10, 0, 16'h0000, 1'b0);
        6'd3: step = mk(8'hB0, 1, 16'h0000, 1'b0);
        default: step = '0;
      endcase
    end else begin
      case (idx)
        6'd0:  step = mk(8'h00, 0, 16'h0000, 1'b1);
        6'd1:  step = mk(8'h00, 0, 16'h0000, 1'b1);
        6'd2:  step = mk(8'h00, 0, 16'h0000, 1'b1);
        6'd3:  step = mk(8'hB0, 1, 16'h0017, 1'b0);
        6'd4:  step = mk(8'hBC, 1, 16'h0080, 1'b0);
        6'd5:  step = mk(8'h3B, 1, 16'h0000, 1'b0);
        6'd6:  step = mk(8'hB0, 1, 16'h0016, 1'b0);
        6'd7:  step = mk(8'hB8, 2, 16'hFFF9, 1'b0);
        6'd8:  step = mk(8'h11, 0, 16'h0000, 1'b0);
        6'd9:  step = mk(8'hBA, 1, 16'h0001, 1'b0);
        6'd10: step = mk(8'hBB, 1, 16'h0000, 1'b0);
        6'd11: step = mk(8'h3A, 1, 16'h0060, 1'b0);
        6'd12: step = mk(8'hBF, 1, 16'h0010, 1'b0);
        6'd13: step = mk(8'hB1, 1, 16'h0056, 1'b0);
        6'd14: step = mk(8'hB2, 1, 16'h0033, 1'b0);
        6'd15: step = mk(8'hB3, 1, 16'h0011, 1'b0);
        6'd16: step = mk(8'hB3, 1, 16'h0011, 1'b0);
        6'd17: step = mk(8'hB4, 1, 16'h0002, 1'b0);
        6'd18: step = mk(8'hB5, 1, 16'h002B, 1'b0);
        6'd19: step = mk(8'hB6, 1, 16'h0040, 1'b0);
        6'd20: step = mk(8'hB7, 1, 16'h0003, 1'b0);
        6'd21: step = mk(8'hB9, 1, 16'h0004, 1'b0);
        6'd22: step = mk(8'hBD, 1, 16'h0004, 1'b0);
        6'd23: step = mk(8'hBE, 1, 16'h0000, 1'b0);
        6'd24: step = mk(8'hC0, 1, 16'h0011, 1'b0);
        6'd25: step = mk(8'hC1, 1, 16'h0011, 1'b0);
        6'd26: step = mk(8'hC2, 1, 16'h0011, 1'b0);
        6'd27: step = mk(8'hC3, 2, 16'h2040, 1'b0);
        6'd28: step = mk(8'hC4, 2, 16'h60C0, 1'b0);
        6'd29: step = mk(8'hC5, 2, 16'h1020, 1'b0);
        6'd30: step = mk(8'hC6, 2, 16'h60C0, 1'b0);
        6'd31: step = mk(8'hC7, 2, 16'h5533, 1'b0);
        6'd32: step = mk(8'hC8, 1, 16'h0000, 1'b0);
        6'd33: step = mk(8'hC9, 1, 16'h0000, 1'b0);
        6'd34: step = mk(8'hCA, 1, 16'h0000, 1'b0);
        6'd35: step = mk(8'hEC, 2, 16'h01F0, 1'b0);
        6'd36: step = mk(8'hCF, 1, 16'h0002, 1'b0);
        6'd37: step = mk(8'hD0, 2, 16'h0804, 1'b0);
        6'd38: step = mk(8'hD1, 1, 16'h0001, 1'b0);
        6'd39: step = mk(8'hD2, 2, 16'h0000, 1'b0);
        6'd40: step = mk(8'hD3, 2, 16'h0D0E, 1'b0);
        6'd41: step = mk(8'hD4, 2, 16'h11A4, 1'b0);
        6'd42: step = mk(8'hD5, 1, 16'h000E, 1'b0);
        6'd43: step = mk(8'h29, 0, 16'h0000, 1'b0);
        default: step = '0;
      endcase
    end
  end

  assign last = sel_down ? (idx == IDX_W'(DN_STEPS - 1))
                         : (idx == IDX_W'(UP_STEPS - 1));
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int WAIT_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = run_q && (cnt_q == CNT_W'(WAIT_CYC - 1));
  assign cnt_en  = start || run_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (expired) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R2
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CNT_W'(WAIT_CYC)));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int WAIT_CYC = 125000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_req,
  input  logic        dis_req,
  output logic        wr_req,
  output logic [7:0]  wr_addr,
  output logic [1:0]  wr_len,
  output logic [15:0] wr_data,
  input  logic        wr_done,
  input  logic        wr_err,
  output logic        busy,
  output logic        active,
  output logic        err
);
  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             down_q, down_d;
  logic             acc_q, acc_d;
  logic             act_q, act_d;
  logic             err_q, err_d;
  logic             tmr_start, tmr_exp;
  logic             acc_now;
  step_t            cur;
  logic             cur_last;

  pps_table u_table (
    .sel_down (down_q),
    .idx      (idx_q),
    .step     (cur),
    .last     (cur_last)
  );

  pps_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .expired (tmr_exp)
  );

  assign acc_now = acc_q | wr_err;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    down_d    = down_q;
    acc_d     = acc_q;
    act_d     = act_q;
    err_d     = err_q;
    tmr_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_req && !act_q) begin
          st_d   = ST_ISSUE;
          down_d = 1'b0;
          idx_d  = '0;
          acc_d  = 1'b0;
          err_d  = 1'b0;
        end else if (dis_req && act_q) begin
          st_d   = ST_ISSUE;
          down_d = 1'b1;
          idx_d  = '0;
          acc_d  = 1'b0;
          err_d  = 1'b0;
        end
      end
      ST_ISSUE: begin
        if (wr_done) begin
          if (!down_q && (idx_q < IDX_W'(PRE_STEPS)) && wr_err) begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end else begin
            acc_d = acc_now;
            if (cur_last) begin
              st_d  = ST_IDLE;
              err_d = acc_now;
              act_d = !down_q && !acc_now;
            end else if (cur.pause) begin
              st_d      = ST_PAUSE;
              tmr_start = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
      end
      ST_PAUSE: begin
        if (tmr_exp) begin
          st_d  = ST_ISSUE;
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      down_q <= 1'b0;
      acc_q  <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      down_q <= down_d;
      acc_q  <= acc_d;
      act_q  <= act_d;
      err_q  <= err_d;
    end
  end

  assign wr_req  = (st_q == ST_ISSUE);
  assign wr_addr = cur.addr;
  assign wr_len  = cur.len;
  assign wr_data = cur.data;
  assign busy    = (st_q != ST_IDLE);
  assign active  = act_q;
  assign err     = err_q;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_len)
                              && $stable(wr_data)));

  // R7
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(wr_done) && $past(wr_addr) == 8'h29 && !$past(wr_err)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_req);

  // R9
  no_redundant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en_req && !dis_req && active) |=> !busy);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && err));
endmodule

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;
  localparam int WAITN = 5;

  typedef struct {
    logic [7:0]  addr;
    logic [1:0]  len;
    logic [15:0] data;
    int          gap;
    bit          inj;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, en_req, dis_req, wr_done, wr_err;
  logic wr_req, busy, active, err;
  logic [7:0]  wr_addr;
  logic [1:0]  wr_len;
  logic [15:0] wr_data;

  int checks = 0, fails = 0;
  int lat = 0;
  bit ended = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  panel_pwr_seq #(.WAIT_CYC(WAITN)) dut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err), .busy(busy), .active(active), .err(err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Wake table from requirements R2 and R3: {addr, len, data}
  function automatic logic [25:0] up_ent(input int i);
    case (i)
      0, 1, 2: return {8'h00, 2'd0, 16'h0000};
      3:  return {8'hB0, 2'd1, 16'h0017};  4:  return {8'hBC, 2'd1, 16'h0080};
      5:  return {8'h3B, 2'd1, 16'h0000};  6:  return {8'hB0, 2'd1, 16'h0016};
      7:  return {8'hB8, 2'd2, 16'hFFF9};  8:  return {8'h11, 2'd0, 16'h0000};
      9:  return {8'hBA, 2'd1, 16'h0001};  10: return {8'hBB, 2'd1, 16'h0000};
      11: return {8'h3A, 2'd1, 16'h0060};  12: return {8'hBF, 2'd1, 16'h0010};
      13: return {8'hB1, 2'd1, 16'h0056};  14: return {8'hB2, 2'd1, 16'h0033};
      15: return {8'hB3, 2'd1, 16'h0011};  16: return {8'hB3, 2'd1, 16'h0011};
      17: return {8'hB4, 2'd1, 16'h0002};  18: return {8'hB5, 2'd1, 16'h002B};
      19: return {8'hB6, 2'd1, 16'h0040};  20: return {8'hB7, 2'd1, 16'h0003};
      21: return {8'hB9, 2'd1, 16'h0004};  22: return {8'hBD, 2'd1, 16'h0004};
      23: return {8'hBE, 2'd1, 16'h0000};  24: return {8'hC0, 2'd1, 16'h0011};
      25: return {8'hC1, 2'd1, 16'h0011};  26: return {8'hC2, 2'd1, 16'h0011};
      27: return {8'hC3, 2'd2, 16'h2040};  28: return {8'hC4, 2'd2, 16'h60C0};
      29: return {8'hC5, 2'd2, 16'h1020};  30: return {8'hC6, 2'd2, 16'h60C0};
      31: return {8'hC7, 2'd2, 16'h5533};  32: return {8'hC8, 2'd1, 16'h0000};
      33: return {8'hC9, 2'd1, 16'h0000};  34: return {8'hCA, 2'd1, 16'h0000};
      35: return {8'hEC, 2'd2, 16'h01F0};  36: return {8'hCF, 2'd1, 16'h0002};
      37: return {8'hD0, 2'd2, 16'h0804};  38: return {8'hD1, 2'd1, 16'h0001};
      39: return {8'hD2, 2'd2, 16'h0000};  40: return {8'hD3, 2'd2, 16'h0D0E};
      41: return {8'hD4, 2'd2, 16'h11A4};  42: return {8'hD5, 2'd1, 16'h000E};
      default: return {8'h29, 2'd0, 16'h0000};
    endcase
  endfunction

  // Sleep table from R8
  function automatic logic [25:0] dn_ent(input int i);
    case (i)
      0: return {8'h28, 2'd0, 16'h0000};
      1: return {8'hB8, 2'd2, 16'h8002};
      2: return {8'h10, 2'd0, 16'h0000};
      default: return {8'hB0, 2'd1, 16'h0000};
    endcase
  endfunction

  task automatic push_up(input int err_at, input int stop_at);
    for (int i = 0; i <= stop_at; i++) begin
      exp_t e;
      {e.addr, e.len, e.data} = up_ent(i);
      e.gap = (i == 0) ? -1 : ((i <= 3) ? WAITN : 0);
      e.inj = (i == err_at);
      q.push_back(e);
    end
  endtask

  task automatic push_dn(input int err_at);
    for (int i = 0; i < 4; i++) begin
      exp_t e;
      {e.addr, e.len, e.data} = dn_ent(i);
      e.gap = (i == 0) ? -1 : 0;
      e.inj = (i == err_at);
      q.push_back(e);
    end
  endtask

  // Monitor / responder: pops expected items and compares each request
  initial begin
    int gap = 0;
    bit fresh = 0;
    wr_done = 1'b0;
    wr_err  = 1'b0;
    forever begin
      if (!fresh) @(negedge clk);
      fresh = 0;
      if (!rst_n || !wr_req) begin
        gap++;
      end else begin
        exp_t e;
        logic [25:0] snap;
        if (q.size() == 0) begin
          check(1'b0, "R9/R10 unexpected request", {wr_addr, wr_len, wr_data}, 0);
          e.addr = wr_addr; e.len = wr_len; e.data = wr_data; e.gap = -1; e.inj = 0;
        end else begin
          e = q.pop_front();
          check({wr_addr, wr_len, wr_data} == {e.addr, e.len, e.data},
                "R3/R8 entry", {wr_addr, wr_len, wr_data}, {e.addr, e.len, e.data});
          if (e.gap >= 0) check(gap == e.gap, "R2 idle gap", gap, e.gap);
        end
        snap = {wr_addr, wr_len, wr_data};
        for (int k = 0; k < lat; k++) @(negedge clk);
        if (lat > 0)
          check(wr_req && {wr_addr, wr_len, wr_data} == snap, "R4 hold",
                {wr_addr, wr_len, wr_data}, snap);
        lat = (lat + 1) % 4;
        wr_done = 1'b1;
        wr_err  = e.inj;
        @(negedge clk);
        wr_done = 1'b0;
        wr_err  = 1'b0;
        gap   = 0;
        fresh = 1;
      end
    end
  end

  task automatic pulse(input bit e, input bit d);
    @(negedge clk);
    en_req  = e;
    dis_req = d;
    @(negedge clk);
    en_req  = 1'b0;
    dis_req = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; en_req = 1'b0; dis_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, active, err, wr_req} == 4'b0, "R1 reset outputs", {busy, active, err, wr_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R7 clean wake
    push_up(-1, 43);
    pulse(1, 0);
    check(busy == 1'b1, "R10 busy after request", busy, 1);
    wait_idle();
    check(q.size() == 0, "R3 wake table complete", q.size(), 0);
    check(active == 1'b1 && err == 1'b0, "R7 active after clean wake", {active, err}, 2'b10);

    // R9 enable while active
    pulse(1, 0);
    check(busy == 1'b0, "R9 enable while active", busy, 0);
    repeat (4) @(negedge clk);
    check(active == 1'b1, "R9 active unchanged", active, 1);

    // R8 clean sleep
    push_dn(-1);
    pulse(0, 1);
    wait_idle();
    check(q.size() == 0, "R8 sleep table complete", q.size(), 0);
    check(active == 1'b0 && err == 1'b0, "R8 flags after sleep", {active, err}, 0);

    // R9 disable while inactive
    pulse(0, 1);
    check(busy == 1'b0, "R9 disable while inactive", busy, 0);

    // R6 late error in wake table
    push_up(20, 43);
    pulse(1, 0);
    wait_idle();
    check(q.size() == 0, "R6 all entries still sent", q.size(), 0);
    check(active == 1'b0 && err == 1'b1, "R6 wake error verdict", {active, err}, 2'b01);

    // R5 preamble error aborts
    push_up(1, 1);
    pulse(1, 0);
    wait_idle();
    repeat (20) @(negedge clk);
    check(q.size() == 0 && busy == 1'b0, "R5 stop after preamble error", {q.size(), busy}, 0);
    check(active == 1'b0 && err == 1'b1, "R5 flags after abort", {active, err}, 2'b01);

    // R10 requests during busy ignored; R7 err cleared by clean wake
    push_up(-1, 43);
    pulse(1, 0);
    repeat (30) @(negedge clk);
    pulse(0, 1);
    pulse(1, 0);
    wait_idle();
    check(q.size() == 0, "R10 no extra writes", q.size(), 0);
    check(active == 1'b1 && err == 1'b0, "R7 clean wake clears err", {active, err}, 2'b10);

    // R9 both requests while active: sleep runs; R6 error in sleep
    push_dn(2);
    pulse(1, 1);
    wait_idle();
    check(q.size() == 0, "R9 both requests run sleep", q.size(), 0);
    check(active == 1'b0 && err == 1'b1, "R6 sleep error verdict", {active, err}, 2'b01);

    // R9 both requests while inactive: wake runs
    push_up(-1, 43);
    pulse(1, 1);
    wait_idle();
    check(q.size() == 0 && active == 1'b1, "R9 both requests run wake", {q.size(), active}, 1);

    summary();
  end
endmodule